// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that gives a host read and write access to a small file of 5-bit configuration registers. The host uses four wires: an active-low select, a serial clock, a data input and a data output. Every transaction is exactly sixteen serial clock periods long. It carries a direction flag, a register address, an idle gap and then either eight data bits from the host or five register bits back to it. Every register bit is presented continuously on a flat output bus, which the rest of the device reads.

The serial pins are asynchronous to the block clock. They are brought into the `clk` domain through synchronizer stages, and the serial clock edges are recovered there. The data output is delivered as a value plus an output-enable. The pad ring builds the tri-state driver from these two signals, so the data-in and data-out wires can be tied together. The serial clock has to be slow enough for each of its phases to span several `clk` cycles.

The host lowers the select at a falling serial clock edge. Each rising edge after that carries one bit. The bit order within the frame is part of the behaviour and is listed below.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads 00000, `cfg_regs` is all zero and `spi_dout_en` is low.
- R2: A frame is counted in rising serial clock edges while the select is low. Rise 1 carries the direction, where 0 means write and 1 means read. Rises 2, 3 and 4 carry address bits 0, 1 and 2, LSB first. Rises 5 to 8 are an idle gap. Rises 9 to 16 carry data bits D0 to D7, LSB first. A write to address k, for k from 0 to 4, stores D0..D4 in register k, which sits at `cfg_regs[5k+4:5k]`.
- R3: On a write, data bits D5, D6 and D7 are discarded and have no effect on any register.
- R4: A write to address 5, 6 or 7 leaves every register unchanged.
- R5: A write takes effect only on the 16th rising edge. If the select rises before that edge, the frame is dropped and no register changes.
- R6: On a read, `spi_dout_en` rises after the falling edge that follows rise 8. From that falling edge on, each falling edge presents the next bit of the addressed register, D0 first, so that rises 9 to 13 see D0 to D4. The slots at rises 14 to 16 read 0.
- R7: A read of address 5, 6 or 7 returns 0 in all eight data slots.
- R8: `spi_dout_en` is low during the direction, address and gap bits, low for a write, low while the select is high, and low again after the falling edge that follows rise 16.
- R9: A read frame never changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_clk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Transaction select, active low |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial read data value |
| spi_dout_en | output | 1 | Drive enable for the serial data output pad |
| cfg_regs | output | 25 | All register bits, register k at bits [5k+4:5k] |

## Verification
The hardest case to reach is a write that is cut short just before its commit point. The select rises after rise 15, with the full address and almost all the data already shifted in. To reach it, the stimulus raises the select after an exact number of serial clock rises, first 10 and then 15. It then reads the target register back through a normal frame. A behavioural model of the register contents is compared against `cfg_regs` on every clock outside frames, so a commit that happens too early or goes to the wrong place shows up at once.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned DEF_NREG   = 5;
  localparam int unsigned DEF_REG_W  = 5;
  localparam int unsigned DEF_ADDR_W = 3;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_GAP    = 4;
  localparam int unsigned DEF_SYNC   = 2;

  // serial pin events recovered in the clk domain
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_act;
    logic sdi;
  } port_evt_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync
  import sreg_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk,
  input  logic      cs_n,
  input  logic      sdi,
  output port_evt_t evt
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_sh, cs_sh, sdi_sh;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      cs_sh   <= '1;
      sdi_sh  <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk};
      cs_sh   <= {cs_sh[STAGES-2:0], cs_n};
      sdi_sh  <= {sdi_sh[STAGES-2:0], sdi};
      sclk_d  <= sclk_sh[TOP];
    end
  end

  always_comb begin
    evt.sclk_rise = sclk_sh[TOP] & ~sclk_d;
    evt.sclk_fall = ~sclk_sh[TOP] & sclk_d;
    evt.cs_act    = ~cs_sh[TOP];
    evt.sdi       = sdi_sh[TOP];
  end
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int unsigned NREG   = DEF_NREG,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned GAP    = DEF_GAP,
  localparam int unsigned FRAME = 1 + ADDR_W + GAP + DATA_W,
  localparam int unsigned CNT_W = $clog2(FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_evt_t         evt,
  input  logic [REG_W-1:0]  rd_word,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              is_read,
  output logic              dout,
  output logic              dout_en
);
  localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] C_GAP_END  = CNT_W'(1 + ADDR_W + GAP);
  localparam logic [CNT_W-1:0] C_FRAME    = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME - 1);

  logic [DATA_W-1:0] data_q, data_nx, out_sh;
  logic              addr_ok;

  assign data_nx = {evt.sdi, data_q[DATA_W-1:1]};
  assign addr_ok = (int'(reg_addr) < int'(NREG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      is_read  <= 1'b0;
      reg_addr <= '0;
      data_q   <= '0;
      out_sh   <= '0;
      dout_en  <= 1'b0;
    end else if (!evt.cs_act) begin
      bit_cnt <= '0;
      is_read <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      if (evt.sclk_rise && bit_cnt != C_FRAME) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == '0)
          is_read <= evt.sdi;
        else if (bit_cnt < C_ADDR_END)
          reg_addr <= {evt.sdi, reg_addr[ADDR_W-1:1]};
        else if (bit_cnt >= C_GAP_END)
          data_q <= data_nx;
      end
      if (evt.sclk_fall) begin
        if (bit_cnt == C_GAP_END && is_read) begin
          dout_en <= 1'b1;
          out_sh  <= {{(DATA_W-REG_W){1'b0}}, rd_word};
        end else if (bit_cnt == C_FRAME) begin
          dout_en <= 1'b0;
        end else if (dout_en) begin
          out_sh <= out_sh >> 1;
        end
      end
    end
  end

  // commit on the last rise only, with the final bit taken straight from the pin
  assign wr_en   = evt.cs_act && evt.sclk_rise && bit_cnt == C_LAST && !is_read && addr_ok;
  assign wr_data = data_nx[REG_W-1:0];
  assign dout    = out_sh[0];
endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
  parameter int unsigned NREG   = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W-1:0]      rd_data,
  output logic [NREG*REG_W-1:0] cfg
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[g*REG_W +: REG_W] <= '0;
      else if (wr_en && int'(addr) == g)
        cfg[g*REG_W +: REG_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (int'(addr) == k) rd_data = cfg[k*REG_W +: REG_W];
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int unsigned NREG   = DEF_NREG,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned GAP    = DEF_GAP,
  parameter int unsigned SYNC   = DEF_SYNC,
  localparam int unsigned FRAME = 1 + ADDR_W + GAP + DATA_W,
  localparam int unsigned CNT_W = $clog2(FRAME + 1),
  localparam int unsigned CFG_W = NREG * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_clk,
  input  logic             spi_cs_n,
  input  logic             spi_din,
  output logic             spi_dout,
  output logic             spi_dout_en,
  output logic [CFG_W-1:0] cfg_regs
);
  port_evt_t         evt;
  logic              cs_act;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_en, is_read;
  logic [REG_W-1:0]  wr_data, rd_word;
  logic [CNT_W-1:0]  bit_cnt;

  assign cs_act = evt.cs_act;

  sreg_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_clk), .cs_n(spi_cs_n), .sdi(spi_din), .evt(evt)
  );

  sreg_frame #(
    .NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP(GAP)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_word(rd_word), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .bit_cnt(bit_cnt), .is_read(is_read),
    .dout(spi_dout), .dout_en(spi_dout_en)
  );

  sreg_file #(.NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_word), .cfg(cfg_regs)
  );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned CFG_W    = 25,
  parameter int unsigned LATE_CNT = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             commit,
  input logic             is_read,
  input logic             dout,
  input logic             dout_en,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [CFG_W-1:0] cfg
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !dout_en); // R8

  AST_CFG_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg)); // R2

  AST_READ_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && is_read) |=> $stable(cfg)); // R9

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> is_read); // R6

  AST_UPPER_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && bit_cnt >= CNT_W'(LATE_CNT)) |-> !dout); // R6
endmodule

bind sreg_port sreg_port_chk #(
  .CNT_W(CNT_W), .CFG_W(CFG_W), .LATE_CNT(1 + ADDR_W + GAP + REG_W + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .commit(wr_en), .is_read(is_read),
  .dout(spi_dout), .dout_en(spi_dout_en), .bit_cnt(bit_cnt), .cfg(cfg_regs)
);

// File: tb/sreg_port_test.sv
module sreg_port_test;
  localparam int HP = 6;
  localparam int NR = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic        dout, dout_en;
  logic [24:0] cfg;

  int checks = 0, failures = 0;
  int model[NR];
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sreg_port uut (
    .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_cs_n(cs_n), .spi_din(sdi),
    .spi_dout(dout), .spi_dout_en(dout_en), .cfg_regs(cfg)
  );

  function automatic logic [24:0] exp_cfg();
    logic [24:0] e;
    for (int k = 0; k < NR; k++) e[k*5 +: 5] = model[k][4:0];
    return e;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R9: register image compared on every clock outside frames
  always @(negedge clk) begin
    if (cmp_en && !done) chk("R2/R9 cfg image", int'(cfg), int'(exp_cfg()));
  end

  task automatic xfer(input bit rd, input int adr, input int dat, input int nrise, input int exp_rd);
    logic [15:0] bits;
    bits = '0;
    bits[0] = rd;
    bits[3:1] = adr[2:0];
    if (!rd) bits[15:8] = dat[7:0];
    cmp_en = 1'b0;
    @(negedge clk); sclk = 1'b0; cs_n = 1'b0; sdi = bits[0];
    for (int i = 1; i <= nrise; i++) begin
      repeat (HP - 1) @(negedge clk);
      if (i >= 2 && i <= 8) chk("R8 no drive before data", int'(dout_en), 0);
      if (i >= 9) begin
        if (rd) begin
          chk("R6 drive during read data", int'(dout_en), 1);
          chk("R6/R7 read bit", int'(dout), (exp_rd >> (i - 9)) & 1);
        end else chk("R8 no drive on write", int'(dout_en), 0);
      end
      @(negedge clk); sclk = 1'b1;
      repeat (HP - 1) @(negedge clk);
      @(negedge clk); sclk = 1'b0;
      if (i < 16) sdi = bits[i];
    end
    repeat (HP) @(negedge clk);
    if (nrise == 16) chk("R8 released after last fall", int'(dout_en), 0);
    cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 no drive with select high", int'(dout_en), 0);
    if (!rd && nrise == 16 && adr < NR) model[adr] = dat & 31;
    cmp_en = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < NR; k++) model[k] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", int'(cfg), 0);
    chk("R1 reset drive enable", int'(dout_en), 0);
    cmp_en = 1'b1;

    // R2 basic writes across the address range
    xfer(0, 0, 8'h15, 16, 0);
    xfer(0, 4, 8'h0A, 16, 0);
    xfer(0, 1, 8'h13, 16, 0);
    xfer(0, 3, 8'h01, 16, 0);
    chk("R2 reg4 field", int'(cfg[24:20]), 5'h0A);
    // R3 upper data bits discarded
    xfer(0, 2, 8'hFF, 16, 0);
    chk("R3 upper bits dropped", int'(cfg[14:10]), 5'h1F);
    xfer(0, 2, 8'hE6, 16, 0);
    chk("R3 upper bits dropped", int'(cfg[14:10]), 5'h06);
    // R4 reserved writes
    xfer(0, 5, 8'h1F, 16, 0);
    xfer(0, 6, 8'h1F, 16, 0);
    xfer(0, 7, 8'h1F, 16, 0);
    chk("R4 reserved write ignored", int'(cfg), int'(exp_cfg()));
    // R5 aborted writes
    xfer(0, 1, 8'h0C, 10, 0);
    xfer(0, 1, 8'h0C, 15, 0);
    chk("R5 abort keeps reg1", int'(cfg[9:5]), 5'h13);
    // R6 R9 read back every register
    for (int k = 0; k < NR; k++) xfer(1, k, 0, 16, model[k]);
    // R7 reserved reads
    xfer(1, 6, 0, 16, 0);
    xfer(1, 5, 0, 16, 0);
    // R5 read back the aborted target through the port
    xfer(1, 1, 0, 16, 8'h13);
    chk("R9 reads left image intact", int'(cfg), int'(exp_cfg()));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule